// File: doc/BRIEF.md
# Dual-Mode Timer/Counter Channel

This block is a single timer/counter channel built from two count bytes, a high byte and a low byte. A small control register selects what advances the count: either a machine-cycle enable pulse (timer use) or falling edges on an external count pin, sampled once per machine cycle (counter use). Counting needs the run bit. When gating is enabled, it also needs a high level on an external gate pin.

A two-bit mode field sets the count width. The choices are a 13-bit count (a 5-bit prescaler in the low byte feeding the high byte), a full 16-bit count, or an 8-bit count in the low byte that reloads from the high byte. A fourth value freezes the channel. Each rollover sets a sticky overflow flag. Software clears the flag with a clear strobe, or the interrupt logic clears it with an acknowledge pulse.

Software can load either count byte directly at any time. A load takes precedence over a count step on the same clock.

Top module: `tmr_channel`

## Requirements
- R1: After reset, both count bytes and the overflow flag are 0, and the control register is 0. The channel therefore does not count until the control register is written.
- R2: The control word `ctl_wdata` is laid out as bit 0 run, bit 1 external-count select, bit 2 gate enable, and bits 4:3 mode. While run is 0, the count never changes except through byte writes.
- R3: With external-count select at 0, the count advances by exactly one on each clock where `mc_tick` is 1, and holds on clocks where it is 0.
- R4: With external-count select at 1, `cnt_pin` is sampled on each `mc_tick`. The count advances by one when a sample of 0 follows a sample of 1, so at most one edge counts per machine cycle. Pin activity between ticks is seen only through the next sample.
- R5: With gate enable at 1, the channel counts only while `gate_pin` is 1. With gate enable at 0, `gate_pin` has no effect.
- R6: In mode 01 the two bytes form one 16-bit count {hi, lo}. Stepping from 16'hFFFF gives 16'h0000 and sets the overflow flag.
- R7: In mode 00, bits 4:0 of the low byte form a 5-bit prescaler that carries into the 8-bit high byte, so the channel wraps after 8192 steps. Low-byte bits 7:5 hold their value. Wrapping from hi=FF, prescaler=1F clears the high byte and the prescaler and sets the flag.
- R8: In mode 10 only the low byte counts. A step from lo=FF loads the low byte with the high byte and sets the flag. The high byte is never changed by counting.
- R9: In mode 11 the count bytes never change except through byte writes.
- R10: A write through `hi_we` or `lo_we` loads `wdata` into that byte and overrides any count step or carry into that byte on the same clock.
- R11: The overflow flag stays at 1 until `flag_clr` or `irq_ack` is 1. A rollover on the same clock as a clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine-cycle enable pulse |
| cnt_pin | input | 1 | External count input |
| gate_pin | input | 1 | External gate input |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control word: {mode[1:0], gate_en, ext_sel, run} |
| hi_we | input | 1 | High byte write strobe |
| lo_we | input | 1 | Low byte write strobe |
| wdata | input | 8 | Byte write data |
| flag_clr | input | 1 | Software clear of the overflow flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| hi_q | output | 8 | High count byte |
| lo_q | output | 8 | Low count byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench targets the wrap points of each mode, since each one has its own likely failure.
- A 13-bit count that carried on all eight low bits would need 256 ticks, not 32, to bump the high byte. One that cleared low bits 7:5 at the wrap would read 00 instead of E0.
- In reload mode, a design that zeroed the low byte on overflow, or let the carry reach the high byte, would show the wrong low byte after the wrap.
- In counter mode, pin toggles between machine cycles check that edges are counted from samples, not from raw pin activity. A design that counted every transition would read too high.
- Writes coincident with a step and a carry, and a clear coincident with a rollover, catch a wrong priority choice.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    MODE_W13  = 2'b00,
    MODE_W16  = 2'b01,
    MODE_RLD8 = 2'b10,
    MODE_HALT = 2'b11
  } tmr_mode_e;

  // Control word, MSB first: mode[1:0], gate_en, ext_sel, run
  typedef struct packed {
    tmr_mode_e mode;
    logic      gate_en;
    logic      ext_sel;
    logic      run;
  } tmr_ctl_t;

  localparam int CTL_W = $bits(tmr_ctl_t);

endpackage

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);

  logic last_smp;

  // A fall is a high sample followed by a low sample, both taken on ticks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_smp <= 1'b0;
    else if (tick)  last_smp <= pin;
  end

  assign fall = tick & last_smp & ~pin;

endmodule

// File: rtl/tmr_count_gate.sv
module tmr_count_gate
  import tmr_chan_pkg::*;
(
  input  tmr_ctl_t ctl,
  input  logic     tick,
  input  logic     fall,
  input  logic     gate_pin,
  output logic     step
);

  logic src_evt;
  logic gate_ok;

  assign src_evt = ctl.ext_sel ? fall : tick;
  assign gate_ok = ~ctl.gate_en | gate_pin;
  assign step    = ctl.run & gate_ok & src_evt & (ctl.mode != MODE_HALT);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_chan_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  tmr_mode_e         mode,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic              wrap
);

  localparam int NXT_W = 2 * BYTE_W + 1;

  // Returns {wrap, next_hi, next_lo} for one count step in the given mode.
  function automatic logic [NXT_W-1:0] advance(
    input tmr_mode_e         md,
    input logic [BYTE_W-1:0] hi,
    input logic [BYTE_W-1:0] lo
  );
    logic [BYTE_W-1:0]  nh;
    logic [BYTE_W-1:0]  nl;
    logic [PRESC_W-1:0] p;
    logic               w;
    nh = hi;
    nl = lo;
    w  = 1'b0;
    p  = lo[PRESC_W-1:0];
    case (md)
      MODE_W13: begin
        if (p == {PRESC_W{1'b1}}) begin
          nh = hi + BYTE_W'(1);
          w  = (hi == {BYTE_W{1'b1}});
        end
        p  = p + PRESC_W'(1);
        nl = {lo[BYTE_W-1:PRESC_W], p};
      end
      MODE_W16: begin
        {w, nh, nl} = {1'b0, hi, lo} + NXT_W'(1);
      end
      MODE_RLD8: begin
        if (lo == {BYTE_W{1'b1}}) begin
          nl = hi;
          w  = 1'b1;
        end else begin
          nl = lo + BYTE_W'(1);
        end
      end
      default: ;
    endcase
    return {w, nh, nl};
  endfunction

  logic [NXT_W-1:0]  nxt;
  logic [BYTE_W-1:0] nxt_hi;
  logic [BYTE_W-1:0] nxt_lo;
  logic              nxt_wrap;

  assign nxt                        = advance(mode, hi_q, lo_q);
  assign {nxt_wrap, nxt_hi, nxt_lo} = nxt;
  assign wrap                       = step & nxt_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (hi_we)  hi_q <= wdata;
    else if (step)   hi_q <= nxt_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_q <= '0;
    else if (lo_we)  lo_q <= wdata;
    else if (step)   lo_q <= nxt_lo;
  end

endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  // A rollover beats a clear on the same clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set)   flag <= 1'b1;
    else if (clr)   flag <= 1'b0;
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_chan_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              flag_clr,
  input  logic              irq_ack,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic              ovf_flag
);

  tmr_ctl_t  ctl_r;
  logic      ext_fall;
  logic      cnt_step;
  logic      cnt_wrap;
  logic      flag_drop;
  logic [1:0] ctl_mode;
  logic      ctl_run;
  logic      ctl_gate_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_r <= '0;
    else if (ctl_we) ctl_r <= tmr_ctl_t'(ctl_wdata);
  end

  assign ctl_mode    = ctl_r.mode;
  assign ctl_run     = ctl_r.run;
  assign ctl_gate_en = ctl_r.gate_en;
  assign flag_drop   = flag_clr | irq_ack;

  tmr_fall_detect u_fall (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (mc_tick),
    .pin  (cnt_pin),
    .fall (ext_fall)
  );

  tmr_count_gate u_gate (
    .ctl     (ctl_r),
    .tick    (mc_tick),
    .fall    (ext_fall),
    .gate_pin(gate_pin),
    .step    (cnt_step)
  );

  tmr_count_core #(
    .BYTE_W (BYTE_W),
    .PRESC_W(PRESC_W)
  ) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .step (cnt_step),
    .mode (ctl_r.mode),
    .hi_we(hi_we),
    .lo_we(lo_we),
    .wdata(wdata),
    .hi_q (hi_q),
    .lo_q (lo_q),
    .wrap (cnt_wrap)
  );

  tmr_ovf_flag u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (cnt_wrap),
    .clr  (flag_drop),
    .flag (ovf_flag)
  );

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mc_tick,
  input logic              gate_pin,
  input logic [1:0]        ctl_mode,
  input logic              ctl_run,
  input logic              ctl_gate_en,
  input logic              hi_we,
  input logic              lo_we,
  input logic [BYTE_W-1:0] wdata,
  input logic              flag_clr,
  input logic              irq_ack,
  input logic              step,
  input logic              wrap,
  input logic [BYTE_W-1:0] hi_q,
  input logic [BYTE_W-1:0] lo_q,
  input logic              ovf_flag
);

  p_run_needed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_run && !hi_we && !lo_we) |=> ($stable(hi_q) && $stable(lo_q)));

  p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> mc_tick);

  p_gate_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_gate_en && !gate_pin) |-> !step);

  p_wrap_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ctl_mode == 2'b10 && lo_q == {BYTE_W{1'b1}} && !lo_we)
      |=> (lo_q == $past(hi_q)));

  p_reload_keeps_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode == 2'b10 && !hi_we) |=> $stable(hi_q));

  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode == 2'b11 && !hi_we && !lo_we) |=> ($stable(hi_q) && $stable(lo_q)));

  p_lo_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |=> (lo_q == $past(wdata)));

  p_hi_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |=> (hi_q == $past(wdata)));

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr && !irq_ack) |=> ovf_flag);

  p_flag_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr || irq_ack) && !wrap) |=> !ovf_flag);

endmodule

bind tmr_channel tmr_channel_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mc_tick    (mc_tick),
  .gate_pin   (gate_pin),
  .ctl_mode   (ctl_mode),
  .ctl_run    (ctl_run),
  .ctl_gate_en(ctl_gate_en),
  .hi_we      (hi_we),
  .lo_we      (lo_we),
  .wdata      (wdata),
  .flag_clr   (flag_clr),
  .irq_ack    (irq_ack),
  .step       (cnt_step),
  .wrap       (cnt_wrap),
  .hi_q       (hi_q),
  .lo_q       (lo_q),
  .ovf_flag   (ovf_flag)
);

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b0;
  logic       cnt_pin = 1'b0;
  logic       gate_pin = 1'b0;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic       hi_we = 1'b0;
  logic       lo_we = 1'b0;
  logic [7:0] wdata = '0;
  logic       flag_clr = 1'b0;
  logic       irq_ack = 1'b0;
  logic [7:0] hi_q;
  logic [7:0] lo_q;
  logic       ovf_flag;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_channel u_tmr_channel (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .hi_we(hi_we), .lo_we(lo_we), .wdata(wdata), .flag_clr(flag_clr),
    .irq_ack(irq_ack), .hi_q(hi_q), .lo_q(lo_q), .ovf_flag(ovf_flag)
  );

  // Control encodings: {mode[1:0], gate_en, ext_sel, run}
  localparam logic [4:0] C16_STOP = 5'b01_0_0_0;
  localparam logic [4:0] C16_RUN  = 5'b01_0_0_1;
  localparam logic [4:0] C13_STOP = 5'b00_0_0_0;
  localparam logic [4:0] C13_RUN  = 5'b00_0_0_1;
  localparam logic [4:0] CRL_STOP = 5'b10_0_0_0;
  localparam logic [4:0] CRL_RUN  = 5'b10_0_0_1;
  localparam logic [4:0] CHALT    = 5'b11_0_0_1;
  localparam logic [4:0] CEXT_RUN = 5'b01_0_1_1;
  localparam logic [4:0] CGT_RUN  = 5'b01_1_0_1;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_bytes(input logic [7:0] h, input logic [7:0] l);
    hi_we = 1'b1; wdata = h;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b1; wdata = l;
    @(negedge clk);
    lo_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      mc_tick = 1'b1;
      @(negedge clk);
    end
    mc_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pin_tick(input logic p);
    cnt_pin = p; mc_tick = 1'b1;
    @(negedge clk);
    mc_tick = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count after reset", {hi_q, lo_q}, 16'h0000);
    chk("R1 flag after reset", {15'd0, ovf_flag}, 16'd0);
    ticks(3);
    chk("R1 control reset leaves channel idle", {hi_q, lo_q}, 16'h0000);
  endtask

  task automatic t_timer16();
    wr_ctl(C16_STOP);
    wr_bytes(8'hFF, 8'hFD);
    wr_ctl(C16_RUN);
    idle(3);
    chk("R3 no tick no count", {hi_q, lo_q}, 16'hFFFD);
    ticks(2);
    chk("R3 one step per tick", {hi_q, lo_q}, 16'hFFFF);
    chk("R6 flag low before wrap", {15'd0, ovf_flag}, 16'd0);
    ticks(1);
    chk("R6 16-bit wrap to zero", {hi_q, lo_q}, 16'h0000);
    chk("R6 flag set on wrap", {15'd0, ovf_flag}, 16'd1);
    clear_flag();
    chk("R11 flag_clr clears", {15'd0, ovf_flag}, 16'd0);
  endtask

  task automatic t_run();
    wr_ctl(C16_STOP);
    wr_bytes(8'h00, 8'h10);
    ticks(5);
    chk("R2 run=0 holds count", {hi_q, lo_q}, 16'h0010);
    wr_ctl(C16_RUN);
    ticks(5);
    chk("R2 run=1 counts", {hi_q, lo_q}, 16'h0015);
  endtask

  task automatic t_mode13();
    wr_ctl(C13_STOP);
    wr_bytes(8'h00, 8'h00);
    wr_ctl(C13_RUN);
    ticks(31);
    chk("R7 prescaler before carry", {hi_q, lo_q}, 16'h001F);
    ticks(1);
    chk("R7 carry after 32 steps", {hi_q, lo_q}, 16'h0100);
    wr_ctl(C13_STOP);
    wr_bytes(8'hFF, 8'hFE);
    wr_ctl(C13_RUN);
    ticks(1);
    chk("R7 step below wrap", {hi_q, lo_q}, 16'hFFFF);
    chk("R7 no flag before wrap", {15'd0, ovf_flag}, 16'd0);
    ticks(1);
    chk("R7 13-bit wrap keeps lo[7:5]", {hi_q, lo_q}, 16'h00E0);
    chk("R7 flag on 13-bit wrap", {15'd0, ovf_flag}, 16'd1);
    clear_flag();
  endtask

  task automatic t_reload();
    wr_ctl(CRL_STOP);
    wr_bytes(8'h80, 8'hFE);
    wr_ctl(CRL_RUN);
    ticks(1);
    chk("R8 low byte counts", {hi_q, lo_q}, 16'h80FF);
    ticks(1);
    chk("R8 reload from high byte", {hi_q, lo_q}, 16'h8080);
    chk("R8 flag on reload", {15'd0, ovf_flag}, 16'd1);
    ticks(3);
    chk("R8 counts on from reload", {hi_q, lo_q}, 16'h8083);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R11 irq_ack clears", {15'd0, ovf_flag}, 16'd0);
  endtask

  task automatic t_halt();
    wr_ctl(C16_STOP);
    wr_bytes(8'h12, 8'h34);
    wr_ctl(CHALT);
    ticks(6);
    chk("R9 halt mode holds", {hi_q, lo_q}, 16'h1234);
  endtask

  task automatic t_counter();
    wr_ctl(C16_STOP);
    wr_bytes(8'h00, 8'h00);
    wr_ctl(CEXT_RUN);
    pin_tick(1'b1);
    pin_tick(1'b0);
    pin_tick(1'b0);
    pin_tick(1'b1);
    pin_tick(1'b0);
    pin_tick(1'b1);
    chk("R4 two sampled falls", {hi_q, lo_q}, 16'h0002);
    for (int i = 0; i < 4; i++) begin
      cnt_pin = ~cnt_pin;
      @(negedge clk);
    end
    chk("R4 toggles between ticks ignored", {hi_q, lo_q}, 16'h0002);
    pin_tick(1'b0);
    chk("R4 next sample sees fall", {hi_q, lo_q}, 16'h0003);
    ticks(3);
    chk("R4 low pin with ticks no count", {hi_q, lo_q}, 16'h0003);
  endtask

  task automatic t_gate();
    wr_ctl(C16_STOP);
    wr_bytes(8'h00, 8'h00);
    wr_ctl(CGT_RUN);
    gate_pin = 1'b0;
    ticks(4);
    chk("R5 gate low blocks", {hi_q, lo_q}, 16'h0000);
    gate_pin = 1'b1;
    ticks(4);
    chk("R5 gate high counts", {hi_q, lo_q}, 16'h0004);
    gate_pin = 1'b0;
    wr_ctl(C16_RUN);
    ticks(2);
    chk("R5 gate ignored when disabled", {hi_q, lo_q}, 16'h0006);
  endtask

  task automatic t_prio();
    wr_ctl(C16_STOP);
    wr_bytes(8'h00, 8'h10);
    wr_ctl(C16_RUN);
    mc_tick = 1'b1; lo_we = 1'b1; wdata = 8'h55;
    @(negedge clk);
    mc_tick = 1'b0; lo_we = 1'b0;
    chk("R10 low write beats step", {hi_q, lo_q}, 16'h0055);
    wr_ctl(C16_STOP);
    wr_bytes(8'h00, 8'hFF);
    wr_ctl(C16_RUN);
    mc_tick = 1'b1; hi_we = 1'b1; wdata = 8'h40;
    @(negedge clk);
    mc_tick = 1'b0; hi_we = 1'b0;
    chk("R10 high write beats carry", {hi_q, lo_q}, 16'h4000);
  endtask

  task automatic t_flag();
    wr_ctl(C16_STOP);
    wr_bytes(8'hFF, 8'hFF);
    wr_ctl(C16_RUN);
    mc_tick = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    mc_tick = 1'b0; flag_clr = 1'b0;
    chk("R11 wrap beats clear", {15'd0, ovf_flag}, 16'd1);
    idle(3);
    chk("R11 flag sticky", {15'd0, ovf_flag}, 16'd1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk("R11 ack drops flag", {15'd0, ovf_flag}, 16'd0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer16();
    t_run();
    t_mode13();
    t_reload();
    t_halt();
    t_counter();
    t_gate();
    t_prio();
    t_flag();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule